// File: doc/BRIEF.md
# Iterative AES-128 Block Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key. It computes one cipher round per clock. A processor drives two single-cycle strobes and one direction bit, then polls two ready flags. A key strobe captures the key. The engine then spends ten cycles building the eleven round keys and stores them all. After that, any number of blocks can be processed under the same key without repeating the schedule.

A data strobe captures a block and applies the first key addition in the same cycle. Ten round cycles follow. Encryption reads the stored round keys in ascending order, and decryption reads them in descending order using the inverse round steps. The result stays on the output until the next strobe. Software writes the key, waits for the key flag, writes a block, and waits for the result flag.

Top module: `aes128_iter_core`

## Requirements
- R1: During and after reset, with no strobe applied, `key_ready_o` and `cipher_ready_o` are low and `result_o` is all zero.
- R2: `key_ready_o` stays low for the nine cycles after the clock edge that samples `key_load_i` high, and reads high after the tenth edge following it.
- R3: With `dir_dec_i` = 0, the result is the AES-128 encryption of `block_i` under the loaded key. Key 000102…0f with plaintext 00112233…ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: With `dir_dec_i` = 1, the result is the AES-128 decryption of `block_i` under the loaded key. The vector pair of R3 is inverted.
- R5: An accepted data strobe clears `cipher_ready_o` at the next edge. The flag reads high after the tenth edge following the edge that accepted the strobe, and not before.
- R6: A key strobe drops both ready flags at the next edge and cancels any block operation in flight. That operation never raises `cipher_ready_o`.
- R7: A data strobe sampled while `key_ready_o` is low, or in the same cycle as a key strobe, is ignored. `cipher_ready_o` stays low and `result_o` keeps its value.
- R8: The direction is taken from `dir_dec_i` only in the cycle the data strobe is accepted. Changing it during the ten rounds has no effect on the result.
- R9: While `cipher_ready_o` is high and no strobe arrives, the flag stays high and `result_o` holds its value.
- R10: Byte 0 of the AES state, which is row 0 of column 0, sits at bits [127:120] of `block_i`, `key_i` and `result_o`. Byte 15 sits at bits [7:0]. Columns are filled four bytes at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load_i | input | 1 | Key strobe: capture `key_i` and start the round-key schedule |
| data_load_i | input | 1 | Data strobe: capture `block_i` and start a block operation |
| dir_dec_i | input | 1 | 0 = encrypt, 1 = decrypt, sampled with the data strobe |
| key_i | input | 128 | Cipher key |
| block_i | input | 128 | Plaintext or ciphertext block |
| result_o | output | 128 | Working state; holds the finished result while `cipher_ready_o` is high |
| key_ready_o | output | 1 | All eleven round keys are stored |
| cipher_ready_o | output | 1 | Result of the last accepted block is valid |

## Verification
The bench aims at the points where an off-by-one round counter or a wrong key index would still look plausible.

- **Ready-flag timing (R2, R5).** It samples both flags on every one of the ten cycles after each strobe. A flag that comes up one cycle early or late is reported at once.
- **Decryption key order (R4).** Decryption is checked against a reference model computed in the bench. An engine that walks the keys in the wrong direction, or that leaves out or misplaces the inverse column mix on the last round, gives a wrong block.
- **Ignored data strobes (R7).** Data strobes arrive before any key, and again while a new key is still expanding. A design that accepted them would raise the result flag or change the output.
- **Key strobe mid-block (R6).** A key strobe lands halfway through a block. A leftover round counter would then raise the result flag on a cancelled operation.
- **Direction change mid-block (R8).** The direction input is flipped during a block. A design that read it live would mix encryption and decryption rounds.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, sq;
    logic [7:0] ex;
    r  = 8'h01;
    sq = a;
    ex = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (ex[i]) r = gf_mul(r, sq);
      sq = gf_mul(sq, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] sub_fwd(input logic [7:0] a);
    logic [7:0] v, o;
    logic [7:0] c;
    c = 8'h63;
    v = gf_inv(a);
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
    return o;
  endfunction

  function automatic logic [7:0] sub_inv(input logic [7:0] a);
    logic [7:0] t;
    logic [7:0] d;
    d = 8'h05;
    for (int i = 0; i < 8; i++)
      t[i] = a[(i+2)%8] ^ a[(i+5)%8] ^ a[(i+7)%8] ^ d[i];
    return gf_inv(t);
  endfunction

  // byte n of a state: n = row + 4*column, byte 0 at the top bits
  function automatic logic [7:0] st_byte(input logic [127:0] s, input int n);
    return s[127-8*n -: 8];
  endfunction

  // row r rotated left by r (forward) or right by r (inverse)
  function automatic logic [127:0] rows_rotate(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    int src;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        src = inv ? (c + 4 - r) % 4 : (c + r) % 4;
        o[127-8*(r+4*c) -: 8] = st_byte(s, r + 4*src);
      end
    return o;
  endfunction

  function automatic logic [127:0] cols_mix(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    logic [7:0] coef [4];
    logic [7:0] acc;
    if (inv) begin
      coef[0] = 8'h0e; coef[1] = 8'h0b; coef[2] = 8'h0d; coef[3] = 8'h09;
    end else begin
      coef[0] = 8'h02; coef[1] = 8'h03; coef[2] = 8'h01; coef[3] = 8'h01;
    end
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 4; k++) begin
        acc = 8'h00;
        for (int j = 0; j < 4; j++)
          acc = acc ^ gf_mul(st_byte(s, j + 4*c), coef[(j - k + 4) % 4]);
        o[127-8*(k+4*c) -: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [7:0] round_const(input int k);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 16; i++)
      if (i < k) r = gf_x2(r);
    return r;
  endfunction

  // round key k from round key k-1
  function automatic logic [127:0] key_step(input logic [127:0] prev, input int k);
    logic [31:0] w0, w1, w2, w3, t, rot;
    w0  = prev[127:96];
    w1  = prev[95:64];
    w2  = prev[63:32];
    w3  = prev[31:0];
    rot = {w3[23:0], w3[31:24]};
    t   = {sub_fwd(rot[31:24]), sub_fwd(rot[23:16]), sub_fwd(rot[15:8]), sub_fwd(rot[7:0])};
    t   = t ^ {round_const(k), 24'h0};
    w0  = w0 ^ t;
    w1  = w1 ^ w0;
    w2  = w2 ^ w1;
    w3  = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

endpackage

// File: rtl/aes_key_store.sv
module aes_key_store
  import aes_iter_pkg::*;
#(
  parameter int NR = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [127:0]        key_i,
  output logic [NR:0][127:0]  rk_o,
  output logic                ready_o
);
  localparam int CW = $clog2(NR + 1);
  localparam logic [CW-1:0] LAST = CW'(NR);

  logic [CW-1:0] step_q;
  logic [127:0]  next_key;

  assign next_key = key_step(rk_o[step_q - 1'b1], int'(step_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rk_o    <= '0;
      step_q  <= '0;
      ready_o <= 1'b0;
    end else if (load_i) begin
      rk_o[0] <= key_i;
      step_q  <= CW'(1);
      ready_o <= 1'b0;
    end else if (step_q != '0) begin
      rk_o[step_q] <= next_key;
      if (step_q == LAST) begin
        step_q  <= '0;
        ready_o <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
  import aes_iter_pkg::*;
(
  input  logic [127:0] st_i,
  input  logic [127:0] rk_i,
  input  logic         dec_i,
  input  logic         last_i,
  output logic [127:0] st_o
);
  logic [127:0] sub_f, sub_i;

  // byte substitution commutes with the row rotation, so it is done first
  for (genvar b = 0; b < 16; b++) begin : g_lane
    assign sub_f[127-8*b -: 8] = sub_fwd(st_i[127-8*b -: 8]);
    assign sub_i[127-8*b -: 8] = sub_inv(st_i[127-8*b -: 8]);
  end

  logic [127:0] enc_rot, dec_key;

  assign enc_rot = rows_rotate(sub_f, 1'b0);
  assign dec_key = rows_rotate(sub_i, 1'b1) ^ rk_i;

  always_comb begin
    if (dec_i)
      st_o = last_i ? dec_key : cols_mix(dec_key, 1'b1);
    else
      st_o = (last_i ? enc_rot : cols_mix(enc_rot, 1'b0)) ^ rk_i;
  end
endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core #(
  parameter int NR = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_load_i,
  input  logic         data_load_i,
  input  logic         dir_dec_i,
  input  logic [127:0] key_i,
  input  logic [127:0] block_i,
  output logic [127:0] result_o,
  output logic         key_ready_o,
  output logic         cipher_ready_o
);
  localparam int CW = $clog2(NR + 1);
  localparam logic [CW-1:0] LAST = CW'(NR);

  logic [NR:0][127:0] rk_all;
  logic [CW-1:0]      rnd_q;
  logic               dec_q;
  logic [127:0]       st_q, st_next, rk_sel;
  logic               data_accept;
  logic               round_last;

  aes_key_store #(.NR(NR)) key_i_u (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (key_load_i),
    .key_i   (key_i),
    .rk_o    (rk_all),
    .ready_o (key_ready_o)
  );

  assign data_accept = data_load_i && key_ready_o && !key_load_i;
  assign round_last  = (rnd_q == LAST);
  assign rk_sel      = dec_q ? rk_all[LAST - rnd_q] : rk_all[rnd_q];

  aes_round_unit round_u (
    .st_i   (st_q),
    .rk_i   (rk_sel),
    .dec_i  (dec_q),
    .last_i (round_last),
    .st_o   (st_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= '0;
      rnd_q          <= '0;
      dec_q          <= 1'b0;
      cipher_ready_o <= 1'b0;
    end else if (key_load_i) begin
      rnd_q          <= '0;
      cipher_ready_o <= 1'b0;
    end else if (data_accept) begin
      st_q           <= block_i ^ (dir_dec_i ? rk_all[NR] : rk_all[0]);
      dec_q          <= dir_dec_i;
      rnd_q          <= CW'(1);
      cipher_ready_o <= 1'b0;
    end else if (rnd_q != '0) begin
      st_q <= st_next;
      if (round_last) begin
        rnd_q          <= '0;
        cipher_ready_o <= 1'b1;
      end else begin
        rnd_q <= rnd_q + 1'b1;
      end
    end
  end

  assign result_o = st_q;
endmodule

// File: rtl/aes128_iter_core_chk.sv
module aes128_iter_core_chk #(
  parameter int NR = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         key_load_i,
  input logic         data_load_i,
  input logic         data_accept,
  input logic         key_ready_o,
  input logic         cipher_ready_o,
  input logic [127:0] result_o
);
  localparam int TW = $clog2(NR + 2) + 1;
  localparam logic [TW-1:0] DONE = TW'(NR + 1);

  logic [TW-1:0] kcnt, dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kcnt <= '0;
      dcnt <= '0;
    end else begin
      if (key_load_i)                       kcnt <= TW'(1);
      else if (kcnt != '0 && kcnt != DONE)  kcnt <= kcnt + 1'b1;
      if (key_load_i)                       dcnt <= '0;
      else if (data_accept)                 dcnt <= TW'(1);
      else if (dcnt != '0 && dcnt != DONE)  dcnt <= dcnt + 1'b1;
    end
  end

  assert_key_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kcnt != '0 && kcnt != DONE) |-> !key_ready_o);
  assert_key_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_ready_o) |-> kcnt == DONE);
  assert_res_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cipher_ready_o) |-> dcnt == DONE);
  assert_res_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_accept |=> !cipher_ready_o);
  assert_key_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_load_i |=> (!key_ready_o && !cipher_ready_o));
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_load_i && !key_ready_o && !key_load_i) |=> (!cipher_ready_o && $stable(result_o)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cipher_ready_o && !data_load_i && !key_load_i) |=> (cipher_ready_o && $stable(result_o)));
endmodule

bind aes128_iter_core aes128_iter_core_chk #(.NR(NR)) chk_u (
  .clk            (clk),
  .rst_n          (rst_n),
  .key_load_i     (key_load_i),
  .data_load_i    (data_load_i),
  .data_accept    (data_accept),
  .key_ready_o    (key_ready_o),
  .cipher_ready_o (cipher_ready_o),
  .result_o       (result_o)
);

// File: tb/aes128_iter_core_tb_top.sv
`timescale 1ns/1ps
module aes128_iter_core_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0, data_load = 1'b0, dir_dec = 1'b0;
  logic [127:0] key_v = '0, blk_v = '0;
  logic [127:0] result;
  logic         key_ready, cipher_ready;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  aes128_iter_core dut_i (
    .clk(clk), .rst_n(rst_n), .key_load_i(key_load), .data_load_i(data_load),
    .dir_dec_i(dir_dec), .key_i(key_v), .block_i(blk_v), .result_o(result),
    .key_ready_o(key_ready), .cipher_ready_o(cipher_ready)
  );

  // ---------------- reference model (table based) ----------------
  logic [7:0]  sb [256];
  logic [7:0]  isb [256];
  logic [127:0] ref_rk [11];

  function automatic logic [7:0] m2(input logic [7:0] a);
    return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  task automatic build_tables();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    sb[0] = 8'h63;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    for (int i = 0; i < 256; i++) isb[sb[i]] = i[7:0];
  endtask

  task automatic expand(input logic [127:0] k);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) ref_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] mixcol(input logic [127:0] s);
    logic [0:15][7:0] b;
    logic [7:0] a0, a1, a2, a3, t;
    b = s;
    for (int c = 0; c < 4; c++) begin
      a0 = b[4*c]; a1 = b[4*c+1]; a2 = b[4*c+2]; a3 = b[4*c+3];
      t = a0 ^ a1 ^ a2 ^ a3;
      b[4*c]   = a0 ^ t ^ m2(a0 ^ a1);
      b[4*c+1] = a1 ^ t ^ m2(a1 ^ a2);
      b[4*c+2] = a2 ^ t ^ m2(a2 ^ a3);
      b[4*c+3] = a3 ^ t ^ m2(a3 ^ a0);
    end
    return b;
  endfunction

  function automatic logic [127:0] inv_mixcol(input logic [127:0] s);
    logic [0:15][7:0] b;
    logic [7:0] u, v;
    b = s;
    for (int c = 0; c < 4; c++) begin
      u = m2(m2(b[4*c] ^ b[4*c+2]));
      v = m2(m2(b[4*c+1] ^ b[4*c+3]));
      b[4*c] ^= u; b[4*c+1] ^= v; b[4*c+2] ^= u; b[4*c+3] ^= v;
    end
    return mixcol(b);
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [0:15][7:0] b, n;
    b = pt ^ ref_rk[0];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) n[i] = sb[b[(i + 4*(i%4)) % 16]];
      b = (r < 10) ? mixcol(n) : n;
      b = b ^ ref_rk[r];
    end
    return b;
  endfunction

  function automatic logic [127:0] ref_dec(input logic [127:0] ct);
    logic [0:15][7:0] b, n;
    b = ct ^ ref_rk[10];
    for (int r = 9; r >= 0; r--) begin
      for (int i = 0; i < 16; i++) n[i] = isb[b[(i + 16 - 4*(i%4)) % 16]];
      b = n ^ ref_rk[r];
      if (r > 0) b = inv_mixcol(b);
    end
    return b;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic load_key(input logic [127:0] k);
    @(negedge clk); key_v = k; key_load = 1'b1;
    @(negedge clk); key_load = 1'b0;
    chk1("R6 key flag drop", key_ready, 1'b0);
    chk1("R6 result flag drop", cipher_ready, 1'b0);
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      chk1("R2 key ready timing", key_ready, n == 10);
    end
    expand(k);
  endtask

  task automatic run_block(input logic [127:0] blk, input logic dec, input string req);
    logic [127:0] exp;
    exp = dec ? ref_dec(blk) : ref_enc(blk);
    @(negedge clk); blk_v = blk; dir_dec = dec; data_load = 1'b1;
    @(negedge clk); data_load = 1'b0;
    chk1("R5 result flag clear", cipher_ready, 1'b0);
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      chk1("R5 result ready timing", cipher_ready, n == 10);
    end
    chk128(req, result, exp);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [127:0] held, ct;
    void'($urandom(32'h5eed_a0e5));
    build_tables();
    repeat (3) @(negedge clk);
    chk1("R1 key flag at reset", key_ready, 1'b0);
    chk1("R1 result flag at reset", cipher_ready, 1'b0);
    chk128("R1 result at reset", result, '0);
    rst_n = 1'b1;

    // R7: data strobe before any key was loaded
    @(negedge clk); blk_v = rnd128(); data_load = 1'b1;
    @(negedge clk); data_load = 1'b0;
    repeat (12) @(negedge clk);
    chk1("R7 no key, no result flag", cipher_ready, 1'b0);
    chk128("R7 no key, result kept", result, '0);

    // R3/R4/R10: standard vector both directions
    load_key(128'h000102030405060708090a0b0c0d0e0f);
    run_block(128'h00112233445566778899aabbccddeeff, 1'b0, "R3 encrypt vector");
    chk128("R3 vector literal", result, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk1("R10 byte 0 at top bits", result[127:120] == 8'h69, 1'b1);
    held = result;
    repeat (4) @(negedge clk);
    chk1("R9 flag held", cipher_ready, 1'b1);
    chk128("R9 result held", result, held);
    run_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1, "R4 decrypt vector");
    chk128("R4 vector literal", result, 128'h00112233445566778899aabbccddeeff);

    // R8: direction flipped during the rounds
    ct = 128'hfedcba98765432100123456789abcdef;
    @(negedge clk); blk_v = ct; dir_dec = 1'b0; data_load = 1'b1;
    @(negedge clk); data_load = 1'b0; dir_dec = 1'b1;
    repeat (10) @(negedge clk);
    chk1("R8 flag", cipher_ready, 1'b1);
    chk128("R8 direction latched", result, ref_enc(ct));
    dir_dec = 1'b0;

    // R6: key strobe in the middle of a block; R7: data strobe during expansion
    @(negedge clk); blk_v = ct; data_load = 1'b1;
    @(negedge clk); data_load = 1'b0;
    repeat (3) @(negedge clk);
    key_v = 128'h2b7e151628aed2a6abf7158809cf4f3c; key_load = 1'b1;
    @(negedge clk); key_load = 1'b0;
    chk1("R6 key flag dropped mid block", key_ready, 1'b0);
    chk1("R6 result flag dropped mid block", cipher_ready, 1'b0);
    held = result;
    @(negedge clk); blk_v = rnd128(); data_load = 1'b1;
    @(negedge clk); data_load = 1'b0;
    chk128("R7 strobe during expansion, result kept", result, held);
    repeat (14) @(negedge clk);
    chk1("R6 cancelled block never completes", cipher_ready, 1'b0);
    chk1("R7 strobe during expansion ignored", cipher_ready, 1'b0);
    chk128("R7 result still kept", result, held);
    chk1("R2 key ready after restart", key_ready, 1'b1);
    expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    run_block(128'h3243f6a8885a308d313198a2e0370734, 1'b0, "R3 second key encrypt");

    // random mix
    for (int it = 0; it < 16; it++) begin
      if (it % 4 == 0) load_key(rnd128());
      run_block(rnd128(), $urandom_range(0, 1) == 1, "R3/R4 random block");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule